// File: doc/BRIEF.md
# Interlace-Aware Field Capture Addresser

This block sits beside a line-doubling frame buffer and watches the timing of a low-rate video source. It gets the source pixel clock and the horizontal and vertical sync. From these it works out whether each arriving field is the top or the bottom half of an interlaced picture, and whether the source is interlaced at all. For every pixel that belongs to the visible window it raises a capture enable and gives a buffer write address. It never captures during horizontal or vertical retrace.

Parity comes from where the vertical sync edge falls within the current line. An edge close to a horizontal sync marks a top field. An edge well inside the line, near mid-line, marks a bottom field. The block compares each new field with the one before it. When the parity alternates, the two fields are woven into alternate buffer rows. When the parity repeats, the source is progressive and every line goes to both rows of its pair, so the reader always finds a frame of twice the field height.

The visible window starts a programmable number of lines after vertical sync and a programmable number of pixels after horizontal sync. Its size is fixed by parameters: 640 pixels by 256 lines by default.

Top module: `field_capture_addresser`

## Requirements
- R1: While reset is asserted, `cap_en`, `dup_en`, `field_bottom` and `interlaced` are 0. No capture takes place until the first vertical sync rising edge after reset.
- R2: A vertical sync rising edge sets `field_bottom` in that same clock edge. Let P be the number of clocks since the last horizontal sync rising edge, counted just before the edge, and L the most recently measured line length in clocks. If P < EDGE_WIN or P + EDGE_WIN >= L, `field_bottom` becomes 0 (top field). Otherwise it becomes 1 (bottom field).
- R3: At each vertical sync rising edge, `interlaced` becomes 1 if the new parity differs from the previous field's parity, and 0 if it is the same. The first field after reset is treated as progressive.
- R4: `cap_en` is 1 exactly when all of these hold: the line index (horizontal sync rising edges since the last vertical sync rising edge) lies in [cfg_line_ofs, cfg_line_ofs+ACTIVE_LINES); the pixel index (clocks since the last horizontal sync rising edge) lies in [cfg_pix_ofs, cfg_pix_ofs+ACTIVE_PIX); and neither sync input is high.
- R5: `wr_addr` holds the buffer row in its upper bits and the pixel position (pixel index minus cfg_pix_ofs) in its lower PIX_W bits. The lowest row bit is the parity bit.
- R6: In interlaced mode the row of `wr_addr` is 2 × (line index − cfg_line_ofs) + `field_bottom`.
- R7: In progressive mode the row of `wr_addr` is 2 × (line index − cfg_line_ofs) for either parity. `dup_en` equals `cap_en`, and `dup_addr` carries row 2 × (line index − cfg_line_ofs) + 1 with the same pixel position.
- R8: In interlaced mode `dup_en` stays 0.
- R9: Each field yields exactly ACTIVE_LINES × ACTIVE_PIX capture cycles, minus any window pixels that overlap an asserted horizontal sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_hsync | input | 1 | Source horizontal sync, active high |
| src_vsync | input | 1 | Source vertical sync, active high |
| cfg_line_ofs | input | VCNT_W | Lines from vertical sync to the first captured line |
| cfg_pix_ofs | input | HCNT_W | Clocks from horizontal sync to the first captured pixel |
| cap_en | output | 1 | Current pixel is to be written |
| wr_addr | output | ROW_W+PIX_W | Primary buffer address, {row, pixel} |
| dup_en | output | 1 | Second write of the current pixel (progressive only) |
| dup_addr | output | ROW_W+PIX_W | Address of the second write, odd row of the pair |
| field_bottom | output | 1 | Parity of the current field, 1 = bottom |
| interlaced | output | 1 | Source judged interlaced |

## Verification
The assertions check several properties on every clock:
- Parity and mode change only at a vertical sync edge.
- Nothing is captured before the first field is seen.
- Pixel positions step by one within a captured run, and the row holds still during that run.
- The duplicate write always targets the odd row of the same pair.
- The duplicate write never appears while interlaced.

Only the bench scenarios can show the following:
- Which parity a given sync placement produces, including the exact boundaries of the near-sync tolerance.
- How the mode follows the sequence of fields.
- That the window lands on the programmed offsets and has the right size.

// File: rtl/fca_pkg.sv
package fca_pkg;

  // True when a vertical sync edge at position pos within a line of length
  // len lies within win clocks of a horizontal sync (start or end of line).
  function automatic logic near_line_edge(int unsigned pos, int unsigned len,
                                          int unsigned win);
    return (pos < win) || (pos + win >= len);
  endfunction

  // True when idx lies in the half-open span [start, start+span).
  function automatic logic in_span(int unsigned idx, int unsigned start,
                                   int unsigned span);
    return (idx >= start) && ((idx - start) < span);
  endfunction

  // Lowest row bit of the primary address: the parity in interlaced mode,
  // always the even row of the pair in progressive mode.
  function automatic logic row_lsb(logic woven, logic bottom);
    return woven & bottom;
  endfunction

endpackage

// File: rtl/fca_sync_edges.sv
module fca_sync_edges #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] level_d;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d[i] <= 1'b0;
      else        level_d[i] <= level[i];
    end
    assign rise[i] = level[i] & ~level_d[i];
  end
endmodule

// File: rtl/fca_raster_counter.sv
module fca_raster_counter #(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_rise,
  input  logic              vs_rise,
  output logic [HCNT_W-1:0] hcnt,
  output logic [VCNT_W-1:0] vcnt,
  output logic [HCNT_W-1:0] line_len,
  output logic              armed
);
  localparam logic [HCNT_W-1:0] HMAX = '1;
  localparam logic [VCNT_W-1:0] VMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt     <= '0;
      vcnt     <= '0;
      line_len <= '0;
      armed    <= 1'b0;
    end else begin
      if (hs_rise)           hcnt <= '0;
      else if (hcnt != HMAX) hcnt <= hcnt + 1'b1;

      if (hs_rise) line_len <= (hcnt == HMAX) ? HMAX : hcnt + 1'b1;

      if (vs_rise)                      vcnt <= '0;
      else if (hs_rise && vcnt != VMAX) vcnt <= vcnt + 1'b1;

      if (vs_rise) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/fca_field_detect.sv
module fca_field_detect #(
  parameter int HCNT_W   = 11,
  parameter int EDGE_WIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vs_rise,
  input  logic [HCNT_W-1:0] hcnt,
  input  logic [HCNT_W-1:0] line_len,
  output logic              field_bottom,
  output logic              interlaced
);
  logic seen;
  logic new_bottom;

  assign new_bottom = ~fca_pkg::near_line_edge(32'(hcnt), 32'(line_len),
                                               32'(EDGE_WIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_bottom <= 1'b0;
      interlaced   <= 1'b0;
      seen         <= 1'b0;
    end else if (vs_rise) begin
      interlaced   <= seen & (new_bottom != field_bottom);
      field_bottom <= new_bottom;
      seen         <= 1'b1;
    end
  end
endmodule

// File: rtl/fca_capture_window.sv
module fca_capture_window #(
  parameter int HCNT_W       = 11,
  parameter int VCNT_W       = 10,
  parameter int ACTIVE_PIX   = 640,
  parameter int ACTIVE_LINES = 256,
  parameter int PIX_W        = 10,
  parameter int LINE_W       = 8
) (
  input  logic                     hsync,
  input  logic                     vsync,
  input  logic                     armed,
  input  logic [HCNT_W-1:0]        hcnt,
  input  logic [VCNT_W-1:0]        vcnt,
  input  logic [VCNT_W-1:0]        line_ofs,
  input  logic [HCNT_W-1:0]        pix_ofs,
  input  logic                     field_bottom,
  input  logic                     interlaced,
  output logic                     cap_en,
  output logic [LINE_W+PIX_W:0]    wr_addr,
  output logic                     dup_en,
  output logic [LINE_W+PIX_W:0]    dup_addr
);
  logic              h_ok, v_ok;
  logic [PIX_W-1:0]  pix_rel;
  logic [LINE_W-1:0] line_rel;

  assign h_ok = fca_pkg::in_span(32'(hcnt), 32'(pix_ofs), 32'(ACTIVE_PIX));
  assign v_ok = fca_pkg::in_span(32'(vcnt), 32'(line_ofs), 32'(ACTIVE_LINES));

  assign pix_rel  = PIX_W'(hcnt - pix_ofs);
  assign line_rel = LINE_W'(vcnt - line_ofs);

  assign cap_en = armed & h_ok & v_ok & ~hsync & ~vsync;
  assign dup_en = cap_en & ~interlaced;

  always_comb begin
    wr_addr  = '0;
    dup_addr = '0;
    if (cap_en) begin
      wr_addr  = {line_rel, fca_pkg::row_lsb(interlaced, field_bottom), pix_rel};
      dup_addr = {line_rel, 1'b1, pix_rel};
    end
  end
endmodule

// File: rtl/field_capture_addresser.sv
module field_capture_addresser #(
  parameter int ACTIVE_PIX   = 640,
  parameter int ACTIVE_LINES = 256,
  parameter int HCNT_W       = 11,
  parameter int VCNT_W       = 10,
  parameter int EDGE_WIN     = 16,
  localparam int PIX_W       = $clog2(ACTIVE_PIX),
  localparam int LINE_W      = $clog2(ACTIVE_LINES),
  localparam int ROW_W       = LINE_W + 1,
  localparam int ADDR_W      = ROW_W + PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_hsync,
  input  logic              src_vsync,
  input  logic [VCNT_W-1:0] cfg_line_ofs,
  input  logic [HCNT_W-1:0] cfg_pix_ofs,
  output logic              cap_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              dup_en,
  output logic [ADDR_W-1:0] dup_addr,
  output logic              field_bottom,
  output logic              interlaced
);
  // Internal events, named for the checker.
  logic [1:0]        sync_rise;
  logic              hs_rise, vs_rise;
  logic              armed;
  logic [HCNT_W-1:0] hcnt, line_len;
  logic [VCNT_W-1:0] vcnt;

  fca_sync_edges #(.N(2)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .level ({src_vsync, src_hsync}),
    .rise  (sync_rise)
  );
  assign hs_rise = sync_rise[0];
  assign vs_rise = sync_rise[1];

  fca_raster_counter #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_raster (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_rise  (hs_rise),
    .vs_rise  (vs_rise),
    .hcnt     (hcnt),
    .vcnt     (vcnt),
    .line_len (line_len),
    .armed    (armed)
  );

  fca_field_detect #(.HCNT_W(HCNT_W), .EDGE_WIN(EDGE_WIN)) u_field (
    .clk          (clk),
    .rst_n        (rst_n),
    .vs_rise      (vs_rise),
    .hcnt         (hcnt),
    .line_len     (line_len),
    .field_bottom (field_bottom),
    .interlaced   (interlaced)
  );

  fca_capture_window #(
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .ACTIVE_PIX(ACTIVE_PIX),
    .ACTIVE_LINES(ACTIVE_LINES), .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) u_window (
    .hsync        (src_hsync),
    .vsync        (src_vsync),
    .armed        (armed),
    .hcnt         (hcnt),
    .vcnt         (vcnt),
    .line_ofs     (cfg_line_ofs),
    .pix_ofs      (cfg_pix_ofs),
    .field_bottom (field_bottom),
    .interlaced   (interlaced),
    .cap_en       (cap_en),
    .wr_addr      (wr_addr),
    .dup_en       (dup_en),
    .dup_addr     (dup_addr)
  );
endmodule

// File: rtl/fca_checker.sv
module fca_checker #(
  parameter int PIX_W  = 10,
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_en,
  input logic              dup_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] dup_addr,
  input logic              field_bottom,
  input logic              interlaced,
  input logic              vs_rise,
  input logic              armed
);
  // R1: nothing is written before the first field start
  a_r1_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!cap_en && !dup_en));

  // R3 / R2: parity and mode move only on a vertical sync edge
  a_r3_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> ($stable(interlaced) && $stable(field_bottom)));

  // R5: pixel position advances by one across a captured run
  a_r5_pixel_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && $past(cap_en)) |->
      (wr_addr[PIX_W-1:0] == PIX_W'($past(wr_addr[PIX_W-1:0]) + 1'b1)));

  // R6: the row does not move within a captured run
  a_r6_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && $past(cap_en)) |-> $stable(wr_addr[ADDR_W-1:PIX_W]));

  // R7: the second write is the odd row of the same pair, same pixel
  a_r7_dup_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    dup_en |-> (dup_addr[PIX_W] && !wr_addr[PIX_W] &&
                dup_addr[PIX_W-1:0] == wr_addr[PIX_W-1:0] &&
                dup_addr[ADDR_W-1:PIX_W+1] == wr_addr[ADDR_W-1:PIX_W+1]));

  // R8: no second write while weaving fields
  a_r8_no_dup_woven: assert property (@(posedge clk) disable iff (!rst_n)
    interlaced |-> !dup_en);
endmodule

bind field_capture_addresser fca_checker #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cap_en       (cap_en),
  .dup_en       (dup_en),
  .wr_addr      (wr_addr),
  .dup_addr     (dup_addr),
  .field_bottom (field_bottom),
  .interlaced   (interlaced),
  .vs_rise      (vs_rise),
  .armed        (armed)
);

// File: tb/tb_field_capture_addresser.sv
module tb_field_capture_addresser;
  localparam int APIX = 8, ALIN = 4, HW = 8, VW = 6, WIN = 3;
  localparam int PW = 3, AW = 6;
  localparam int LEN = 40, HSW = 4, VSW = 10, FLINES = 9;

  logic clk = 1'b0, rst_n = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [VW-1:0] lofs;
  logic [HW-1:0] pofs;
  logic cap_en, dup_en, fb, il;
  logic [AW-1:0] wa, da;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int lo = 2, po = 6;
  bit exp_par = 1'b0, exp_il = 1'b0, seen = 1'b0;

  always #4 clk = ~clk;

  assign lofs = VW'(lo);
  assign pofs = HW'(po);

  field_capture_addresser #(
    .ACTIVE_PIX(APIX), .ACTIVE_LINES(ALIN), .HCNT_W(HW), .VCNT_W(VW),
    .EDGE_WIN(WIN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .src_hsync(hs), .src_vsync(vs),
    .cfg_line_ofs(lofs), .cfg_pix_ofs(pofs),
    .cap_en(cap_en), .wr_addr(wa), .dup_en(dup_en), .dup_addr(da),
    .field_bottom(fb), .interlaced(il)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit h, bit v);
    @(negedge clk);
    hs = h;
    vs = v;
    @(posedge clk);
    #1;
  endtask

  // R1: reset values, then no capture before the first vertical sync
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!cap_en, "R1", "cap_en in reset", int'(cap_en), 0);
    chk(!dup_en, "R1", "dup_en in reset", int'(dup_en), 0);
    chk(!fb, "R1", "field_bottom in reset", int'(fb), 0);
    chk(!il, "R1", "interlaced in reset", int'(il), 0);
    rst_n = 1'b1;
    for (int ln = 0; ln < 3; ln++)
      for (int c = 0; c < LEN; c++) begin
        drive(c < HSW, 1'b0);
        if (cap_en || dup_en)
          chk(1'b0, "R1", "capture before first field", 1, 0);
      end
    chk(!cap_en && !dup_en, "R1", "idle after preroll", int'(cap_en), 0);
  endtask

  // One field; vertical sync rises at clock vs_pos of its first line.
  task automatic run_field(int vs_pos);
    int hb, ncap, ecount, row, ea, ed;
    bit nb, h, v, ecap;
    hb = (vs_pos == 0) ? LEN - 1 : vs_pos - 1;
    nb = !((hb < WIN) || (hb + WIN >= LEN));
    exp_il = seen && (nb != exp_par);
    exp_par = nb;
    seen = 1'b1;
    ncap = 0;
    ecount = 0;
    for (int c = po; c < po + APIX; c++) if (c >= HSW) ecount++;
    ecount = ecount * ALIN;
    for (int ln = 0; ln < FLINES; ln++)
      for (int c = 0; c < LEN; c++) begin
        h = (c < HSW);
        v = (ln * LEN + c >= vs_pos) && (ln * LEN + c < vs_pos + VSW);
        drive(h, v);
        ecap = (ln >= lo) && (ln < lo + ALIN) && (c >= po) &&
               (c < po + APIX) && !h && !v;
        if (cap_en != ecap)
          chk(1'b0, "R4", $sformatf("cap_en line %0d pix %0d", ln, c),
              int'(cap_en), int'(ecap));
        if (dup_en != (ecap && !exp_il))
          chk(1'b0, exp_il ? "R8" : "R7", "dup_en", int'(dup_en),
              int'(ecap && !exp_il));
        if (ecap) begin
          ncap++;
          row = 2 * (ln - lo) + (exp_il ? int'(exp_par) : 0);
          ea = row * (1 << PW) + (c - po);
          ed = (2 * (ln - lo) + 1) * (1 << PW) + (c - po);
          if (int'(wa[PW-1:0]) != c - po)
            chk(1'b0, "R5", "pixel field", int'(wa[PW-1:0]), c - po);
          if (int'(wa) != ea)
            chk(1'b0, exp_il ? "R6" : "R7", "wr_addr", int'(wa), ea);
          if (!exp_il && int'(da) != ed)
            chk(1'b0, "R7", "dup_addr", int'(da), ed);
        end
      end
    chk(ncap == ecount, "R9", "captures per field", ncap, ecount);
    chk(fb == exp_par, "R2", $sformatf("parity vs_pos=%0d", vs_pos),
        int'(fb), int'(exp_par));
    chk(il == exp_il, "R3", $sformatf("mode vs_pos=%0d", vs_pos),
        int'(il), int'(exp_il));
    chk(1'b1, "R4", "field window", 0, 0);
  endtask

  // R7 / R3: repeated top fields are progressive and duplicated
  task automatic t_progressive();
    run_field(0);
    run_field(0);
    chk(il == 1'b0 && fb == 1'b0, "R7", "progressive top", int'(il), 0);
    run_field(0);
  endtask

  // R6 / R8: alternating fields are woven
  task automatic t_interlaced();
    run_field(20);
    chk(il == 1'b1, "R6", "interlaced after bottom", int'(il), 1);
    run_field(0);
    run_field(20);
    chk(fb == 1'b1, "R8", "bottom parity kept", int'(fb), 1);
  endtask

  // R2: edges of the near-sync tolerance
  task automatic t_parity_edges();
    run_field(37);
    run_field(38);
    run_field(2);
  endtask

  // R7: progressive bottom-only source still writes the even row first
  task automatic t_bottom_progressive();
    run_field(20);
    run_field(20);
    chk(il == 1'b0 && fb == 1'b1, "R7", "progressive bottom", int'(il), 0);
  endtask

  // R4 / R9: moved window, and a window overlapping horizontal sync
  task automatic t_window();
    lo = 3;
    po = 10;
    run_field(0);
    run_field(0);
    lo = 2;
    po = 2;
    run_field(0);
    run_field(0);
    po = 6;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    t_reset();
    t_progressive();
    t_interlaced();
    t_parity_edges();
    t_bottom_progressive();
    t_window();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      chk(1'b0, "R9", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end
endmodule